// File: doc/BRIEF.md
# Gain-offset calibration sequencer

This controller trims a linear signal path inside a hybrid analog computer. The path has a set of input channels, each scaled by its own coefficient register before the signals are summed and digitized. The sequencer does three things in turn. First it nulls the path offset with the inputs held at the zero reference. Then it measures and corrects the gain of each channel in use, one channel at a time. Finally it nulls the offset a second time, because the new coefficients can shift the offset.

To null the offset, the sequencer holds the reference select at zero and raises a request to an external sample-and-hold unit until that unit acknowledges. To trim a gain, it first clears every coefficient to zero and switches the inputs to the one reference. It then sets exactly one channel's coefficient to unity and waits a programmable settling time. It takes the next valid measurement as that channel's gain and computes the reciprocal with a bit-serial divider. The result is kept internally, and the channel's coefficient is set back to zero so the next channel is measured alone. Once every channel in use has been measured, all corrections are written out together.

A calibration starts by itself when reset is released, and again on each accepted start request before a user run. A sample-and-hold unit that never answers, or a measured gain that is not positive, aborts the run and raises a sticky error flag.

Top module: `gcal_seq`

## Requirements
- R1: With reset held, busy is 1 and done, err, sh_req and coef_we are 0. After reset is released, a full calibration runs to completion without any start request.
- R2: While sh_req is high, ref_sel is 0 (0 selects the zero reference, 1 the one reference). sh_req stays high until a cycle with sh_ack. The first offset-nulling request of a run comes before ref_sel first goes to 1.
- R3: Before ref_sel first goes to 1 in a run, each of the N_CH coefficient addresses (0 to N_CH-1) has been written with 0.
- R4: With ref_sel at 1, each coefficient write is either 0 or unity (0x4000). When a unity write happens, every other coefficient is 0. There is exactly one unity write per channel whose chan_mask bit is 1, in ascending channel order. Channels whose mask bit is 0 are never set to unity.
- R5: After a unity write, meas_valid is ignored for settle_cnt+1 cycles. The first measurement that can be accepted is the one presented in the cycle after that.
- R6: Coefficients and measurements are 16-bit two's complement with 14 fraction bits (unity = 0x4000). For a measured gain m, the final coefficient of a channel in use is floor(2^28 / m), saturated to 0x7FFF. A channel not in use ends at 0.
- R7: A second offset-nulling request, with ref_sel at 0, starts only after every correction has been written. done follows its acknowledge, and each completed run makes exactly two requests.
- R8: busy is high from an accepted start to the end of the done cycle. A start request while busy is ignored. done is a single-cycle pulse.
- R9: A measurement with meas_valid high and a value of 0 or below aborts the run. err is set, busy falls and no done is given. err stays set until the next run is accepted, which clears it.
- R10: If sh_ack has not arrived after sh_req has been high for SH_LIMIT (1024) cycles, the run aborts with err set and no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; release starts the power-up calibration |
| start | input | 1 | Request a calibration run; honoured only while idle |
| chan_mask | input | N_CH | Channels in use, sampled at run start |
| settle_cnt | input | SETTLE_W | Settling cycles after a unity write, sampled at run start |
| meas_data | input | DW | Digitized path output, signed fixed point |
| meas_valid | input | 1 | meas_data carries a fresh conversion |
| sh_ack | input | 1 | Sample-and-hold unit finished nulling |
| busy | output | 1 | A calibration run is in progress |
| done | output | 1 | One-cycle pulse at successful completion |
| err | output | 1 | Sticky abort flag |
| ref_sel | output | 1 | Path input reference: 0 = zero, 1 = one |
| sh_req | output | 1 | Offset-nulling request, held until acknowledged |
| coef_we | output | 1 | Coefficient write strobe |
| coef_addr | output | AW | Coefficient register index |
| coef_data | output | DW | Coefficient write value |

## Verification
The bench models the path as a linear sum of each coefficient times the channel gain. While the last coefficient write is still settling, the model returns -1, so a measurement accepted too early aborts the run and shows up as a missing done. Channel masks range over all channels in use, none in use, a single channel and random sets. Together they separate channel skipping, ascending order and correct clearing. Gains at unity, at full scale and below half scale test the exact reciprocal against saturation. Zero and negative gains, and a sample-and-hold unit that never answers, cover the two abort paths, with start requests sprayed in mid-run to show they are refused.

// File: rtl/gcal_pkg.sv
package gcal_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_START,
      ST_SH1,
      ST_CLR,
      ST_SEL,
      ST_EN,
      ST_SETTLE,
      ST_MEAS,
      ST_DIV,
      ST_UNEN,
      ST_COMMIT,
      ST_SH2,
      ST_DONE
   } gcal_state_t;
endpackage

// File: rtl/gcal_tmr.sv
module gcal_tmr #(
   parameter int CW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] val,
   output logic          zero
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (load)        cnt <= val;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/gcal_recip.sv
module gcal_recip #(
   parameter int DW   = 16,
   parameter int FRAC = 14
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [DW-1:0] dvsr_in,
   output logic          rdy,
   output logic [DW-1:0] quo
);
   localparam int QW = 2 * FRAC + 1;
   localparam int CW = $clog2(QW + 1);
   localparam logic [CW-1:0] LAST_STEP = CW'(QW - 1);

   if (2 * FRAC < DW - 1) begin : g_bad_frac
      $error("gcal_recip: 2*FRAC must reach DW-1");
   end

   logic          act;
   logic [CW-1:0] step;
   logic [DW-1:0] dvsr, rem;
   logic [QW-1:0] q;
   logic [DW:0]   trial, diff;
   logic          ge;

   // the dividend is 2^(2*FRAC): its only set bit enters on the first step
   assign trial = {rem, (step == '0)};
   assign diff  = trial - {1'b0, dvsr};
   assign ge    = (trial >= {1'b0, dvsr});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act  <= 1'b0;
         step <= '0;
         dvsr <= '0;
         rem  <= '0;
         q    <= '0;
         rdy  <= 1'b0;
      end else if (go) begin
         act  <= 1'b1;
         step <= '0;
         dvsr <= dvsr_in;
         rem  <= '0;
         q    <= '0;
         rdy  <= 1'b0;
      end else if (act) begin
         rem  <= ge ? diff[DW-1:0] : trial[DW-1:0];
         q    <= {q[QW-2:0], ge};
         step <= step + 1'b1;
         if (step == LAST_STEP) begin
            act <= 1'b0;
            rdy <= 1'b1;
         end
      end else begin
         rdy <= 1'b0;
      end
   end

   assign quo = (|q[QW-1:DW-1]) ? {1'b0, {(DW-1){1'b1}}} : q[DW-1:0];

   // R9
   div_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> ($signed(dvsr_in) > 0));
   // R6
   div_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> !act);
   // R6
   div_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rdy |=> !rdy);
endmodule

// File: rtl/gcal_seq.sv
module gcal_seq
   import gcal_pkg::*;
#(
   parameter int N_CH     = 8,
   parameter int DW       = 16,
   parameter int FRAC     = 14,
   parameter int SETTLE_W = 8,
   parameter int SH_LIMIT = 1024,
   parameter int AW       = (N_CH > 1) ? $clog2(N_CH) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [N_CH-1:0]     chan_mask,
   input  logic [SETTLE_W-1:0] settle_cnt,
   input  logic [DW-1:0]       meas_data,
   input  logic                meas_valid,
   input  logic                sh_ack,
   output logic                busy,
   output logic                done,
   output logic                err,
   output logic                ref_sel,
   output logic                sh_req,
   output logic                coef_we,
   output logic [AW-1:0]       coef_addr,
   output logic [DW-1:0]       coef_data
);
   localparam int SHW = $clog2(SH_LIMIT) + 1;
   localparam int TW  = (SETTLE_W > SHW) ? SETTLE_W : SHW;
   localparam logic [DW-1:0] UNITY   = {{(DW-1){1'b0}}, 1'b1} << FRAC;
   localparam logic [AW-1:0] LAST    = AW'(N_CH - 1);
   localparam logic [TW-1:0] SH_LOAD = TW'(SH_LIMIT - 1);

   if (N_CH < 2)             begin : g_bad_nch   $error("gcal_seq: N_CH must be at least 2"); end
   if (FRAC > DW - 2)        begin : g_bad_frac  $error("gcal_seq: unity must fit below the sign bit"); end
   if (SH_LIMIT < 2)         begin : g_bad_lim   $error("gcal_seq: SH_LIMIT too small"); end
   if ((1 << AW) < N_CH)     begin : g_bad_aw    $error("gcal_seq: AW too narrow for N_CH"); end

   gcal_state_t         st;
   logic [AW-1:0]       idx;
   logic [N_CH-1:0]     mask_q;
   logic [SETTLE_W-1:0] settle_q;
   logic                err_q;
   logic                is_last;
   logic                meas_pos;
   logic                tmr_load, tmr_zero;
   logic [TW-1:0]       tmr_val;
   logic                div_go, div_rdy;
   logic [DW-1:0]       div_q;
   logic [DW-1:0]       corr [N_CH];

   assign is_last  = (idx == LAST);
   assign meas_pos = ($signed(meas_data) > 0);
   assign div_go   = (st == ST_MEAS) && meas_valid && meas_pos;

   assign tmr_load = (st == ST_START) || (st == ST_EN) || ((st == ST_COMMIT) && is_last);
   assign tmr_val  = (st == ST_EN) ? TW'(settle_q) : SH_LOAD;

   gcal_tmr #(.CW(TW)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (tmr_load),
      .val   (tmr_val),
      .zero  (tmr_zero)
   );

   gcal_recip #(.DW(DW), .FRAC(FRAC)) u_recip (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (div_go),
      .dvsr_in (meas_data),
      .rdy     (div_rdy),
      .quo     (div_q)
   );

   for (genvar gi = 0; gi < N_CH; gi++) begin : g_corr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            corr[gi] <= '0;
         else if ((st == ST_DIV) && div_rdy && (idx == AW'(gi)))
            corr[gi] <= div_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_START;
         idx      <= '0;
         mask_q   <= '0;
         settle_q <= '0;
         err_q    <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE:   if (start) st <= ST_START;
            ST_START: begin
               mask_q   <= chan_mask;
               settle_q <= settle_cnt;
               err_q    <= 1'b0;
               idx      <= '0;
               st       <= ST_SH1;
            end
            ST_SH1: begin
               if (sh_ack) begin
                  idx <= '0;
                  st  <= ST_CLR;
               end else if (tmr_zero) begin
                  err_q <= 1'b1;
                  st    <= ST_IDLE;
               end
            end
            ST_CLR: begin
               if (is_last) begin
                  idx <= '0;
                  st  <= ST_SEL;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            ST_SEL: begin
               if (mask_q[idx]) begin
                  st <= ST_EN;
               end else if (is_last) begin
                  idx <= '0;
                  st  <= ST_COMMIT;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            ST_EN:     st <= ST_SETTLE;
            ST_SETTLE: if (tmr_zero) st <= ST_MEAS;
            ST_MEAS: begin
               if (meas_valid) begin
                  if (meas_pos) begin
                     st <= ST_DIV;
                  end else begin
                     err_q <= 1'b1;
                     st    <= ST_IDLE;
                  end
               end
            end
            ST_DIV:    if (div_rdy) st <= ST_UNEN;
            ST_UNEN: begin
               if (is_last) begin
                  idx <= '0;
                  st  <= ST_COMMIT;
               end else begin
                  idx <= idx + 1'b1;
                  st  <= ST_SEL;
               end
            end
            ST_COMMIT: begin
               if (is_last) st <= ST_SH2;
               else         idx <= idx + 1'b1;
            end
            ST_SH2: begin
               if (sh_ack) begin
                  st <= ST_DONE;
               end else if (tmr_zero) begin
                  err_q <= 1'b1;
                  st    <= ST_IDLE;
               end
            end
            ST_DONE:   st <= ST_IDLE;
            default:   st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      coef_we   = 1'b0;
      coef_data = '0;
      unique case (st)
         ST_CLR, ST_UNEN: coef_we = 1'b1;
         ST_EN: begin
            coef_we   = 1'b1;
            coef_data = UNITY;
         end
         ST_COMMIT: begin
            coef_we   = mask_q[idx];
            coef_data = corr[idx];
         end
         default: ;
      endcase
   end

   assign coef_addr = idx;
   assign busy      = (st != ST_IDLE);
   assign done      = (st == ST_DONE);
   assign err       = err_q;
   assign sh_req    = (st == ST_SH1) || (st == ST_SH2);
   assign ref_sel   = (st == ST_SEL) || (st == ST_EN) || (st == ST_SETTLE) ||
                      (st == ST_MEAS) || (st == ST_DIV) || (st == ST_UNEN);

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R2
   sh_zero_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sh_req |-> !ref_sel);
   // R2
   sh_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_req && !sh_ack && !tmr_zero) |=> sh_req);
   // R4
   unity_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (coef_we && ref_sel) |-> ((coef_data == '0) || (coef_data == UNITY)));
   // R9
   err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(err) |-> (busy && !ref_sel));
   // R8
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (!sh_req && !coef_we));
endmodule

// File: tb/sim_gcal_seq.sv
module sim_gcal_seq;
   localparam int N     = 8;
   localparam int DW    = 16;
   localparam int SW    = 8;
   localparam int LIM   = 1024;
   localparam int UNITY = 16'h4000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [N-1:0]  chan_mask = '0;
   logic [SW-1:0] settle_cnt = '0;
   logic [DW-1:0] meas_data = '0;
   logic          meas_valid = 1'b0;
   logic          sh_ack = 1'b0;
   logic          busy, done, err, ref_sel, sh_req, coef_we;
   logic [2:0]    coef_addr;
   logic [DW-1:0] coef_data;

   gcal_seq #(.N_CH(N), .DW(DW), .FRAC(14), .SETTLE_W(SW), .SH_LIMIT(LIM)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .chan_mask(chan_mask),
      .settle_cnt(settle_cnt), .meas_data(meas_data), .meas_valid(meas_valid),
      .sh_ack(sh_ack), .busy(busy), .done(done), .err(err), .ref_sel(ref_sel),
      .sh_req(sh_req), .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data)
   );

   always #10 clk = ~clk;

   int checks = 0, fails = 0, cyc = 0;
   logic [DW-1:0] mc [N];
   int  gain [N];
   int  age = 0, sh_rises = 0, unity_cnt = 0, last_unity = -1, clr_cnt = 0;
   int  done_cnt = 0, ack_dly = -1, k_cur = 0;
   bit  prev_sh = 0, prev_ref = 0, prev_done = 0, no_ack = 0;
   logic [N-1:0] mask_cur = '0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int exp_corr(input int g);
      int q;
      if (g <= 0) return 0;
      q = (1 << 28) / g;
      return (q > 32767) ? 32767 : q;
   endfunction

   function automatic int coef_mismatch();
      int bad = 0;
      for (int i = 0; i < N; i++) begin
         int e = mask_cur[i] ? exp_corr(gain[i]) : 0;
         if (int'(mc[i]) != e) bad++;
      end
      return bad;
   endfunction

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   // path, sample-and-hold and monitor model, all at the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         int acc;
         int others;
         if (coef_we) age = 0; else if (age < 100000) age++;
         acc = 0;
         for (int i = 0; i < N; i++) acc += ($signed(mc[i]) * gain[i]) >>> 14;
         // R5: the path is not settled until settle_cnt+2 cycles after a write
         meas_data  = (age >= k_cur + 2) ? acc[DW-1:0] : 16'hFFFF;
         meas_valid = ($urandom % 2) == 1;
         // sample-and-hold responder
         if (sh_ack) begin
            sh_ack  = 1'b0;
            ack_dly = -1;
         end else if (sh_req && !no_ack) begin
            if (ack_dly < 0) ack_dly = $urandom % 6;
            else if (ack_dly == 0) sh_ack = 1'b1;
            else ack_dly--;
         end else ack_dly = -1;
         // monitors
         if (sh_req && !prev_sh) begin
            chk(ref_sel == 1'b0, "R2 zero ref at sh_req", ref_sel, 0);
            sh_rises++;
            // R7: every correction is in place before the second nulling
            if (sh_rises == 2)
               chk(coef_mismatch() == 0, "R7 coefs final before second nulling", coef_mismatch(), 0);
         end
         if (ref_sel && !prev_ref && unity_cnt == 0 && last_unity == -1) begin
            others = 0;
            for (int i = 0; i < N; i++) if (mc[i] != '0) others++;
            chk(clr_cnt == N && others == 0, "R3 all cleared before one ref", clr_cnt, N);
            chk(sh_rises == 1, "R2 first nulling before gain phase", sh_rises, 1);
            last_unity = -2;
         end
         if (done) begin
            chk(!prev_done, "R8 done single cycle", prev_done, 0);
            done_cnt++;
         end
         if (coef_we) begin
            if (ref_sel && coef_data == UNITY) begin
               others = 0;
               for (int i = 0; i < N; i++) if (i != coef_addr && mc[i] != '0) others++;
               chk(others == 0, "R4 isolation at unity write", others, 0);
               chk(mask_cur[coef_addr] && int'(coef_addr) > last_unity, "R4 order and skip",
                   coef_addr, last_unity + 1);
               last_unity = coef_addr;
               unity_cnt++;
            end
            if (!ref_sel && sh_rises == 1 && coef_data == '0) clr_cnt++;
            mc[coef_addr] = coef_data;
         end
         prev_sh = sh_req; prev_ref = ref_sel; prev_done = done;
      end
   end

   task automatic prep(input logic [N-1:0] m, input int k);
      chan_mask = m; mask_cur = m; settle_cnt = SW'(k); k_cur = k;
      for (int i = 0; i < N; i++) mc[i] = 16'h1234;
      sh_rises = 0; unity_cnt = 0; last_unity = -1; clr_cnt = 0; done_cnt = 0;
   endtask

   task automatic wait_end(input bit spray);
      for (int t = 0; t < 20000; t++) begin
         @(negedge clk);
         start = 1'b0;
         if (done || (err && !busy)) break;
         start = busy && spray && (($urandom % 40) == 0);
      end
      start = 1'b0;
      @(negedge clk);
   endtask

   task automatic check_ok(input string tag);
      chk(done_cnt == 1 && err == 1'b0, {tag, " R8 run completes"}, done_cnt, 1);
      chk(busy == 1'b0, "R8 busy low after done", busy, 0);
      chk(sh_rises == 2, "R7 two nulling requests", sh_rises, 2);
      chk(unity_cnt == $countones(mask_cur), "R4 one unity write per channel", unity_cnt,
          $countones(mask_cur));
      for (int i = 0; i < N; i++) begin
         int e = mask_cur[i] ? exp_corr(gain[i]) : 0;
         chk(int'(mc[i]) == e, "R6 final coefficient", mc[i], e);
      end
   endtask

   task automatic run(input logic [N-1:0] m, input int k, input string tag);
      prep(m, k);
      @(negedge clk); start = 1'b1;
      wait_end(1'b1);
      check_ok(tag);
   endtask

   initial begin
      for (int i = 0; i < N; i++) gain[i] = 16'h4000 + i * 300;
      prep(8'b1011_0101, 3);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(busy == 1'b1 && done == 1'b0 && err == 1'b0, "R1 reset state busy/done/err", busy, 1);
      chk(sh_req == 1'b0 && coef_we == 1'b0, "R1 reset state sh_req/coef_we", sh_req, 0);
      rst_n = 1'b1;
      wait_end(1'b0);
      check_ok("R1 power-up");

      // directed gains: unity, full scale, below half scale, minimum
      gain[0] = 16'h4000; gain[1] = 16'h7FFF; gain[2] = 16'h1000; gain[3] = 1;
      gain[4] = 16'h2000; gain[5] = 16'h2001; gain[6] = 16'h5555; gain[7] = 16'h3000;
      run(8'hFF, 0, "R6 directed all channels");
      run(8'h00, 5, "R4 no channels");
      run(8'h80, 255, "R5 max settle single channel");
      run(8'h01, 1, "R4 first channel only");

      // R9 zero and negative gain abort, then clearing
      gain[2] = 0;
      prep(8'h0F, 2);
      @(negedge clk); start = 1'b1;
      wait_end(1'b0);
      chk(err == 1'b1 && busy == 1'b0 && done_cnt == 0, "R9 zero gain abort", err, 1);
      gain[2] = -500;
      prep(8'h04, 2);
      @(negedge clk); start = 1'b1;
      wait_end(1'b0);
      chk(err == 1'b1 && done_cnt == 0, "R9 negative gain abort", err, 1);
      chk(err == 1'b1, "R9 err sticky while idle", err, 1);
      gain[2] = 16'h3800;
      run(8'h04, 2, "R9 recovery");
      chk(err == 1'b0, "R9 err cleared by new run", err, 0);

      // R10 sample-and-hold timeout
      begin
         int hi = 0;
         prep(8'h03, 1);
         no_ack = 1;
         @(negedge clk); start = 1'b1;
         @(negedge clk); start = 1'b0;
         for (int t = 0; t < 3000; t++) begin
            @(negedge clk);
            if (err) break;
            if (sh_req) hi++;
         end
         no_ack = 0;
         chk(err == 1'b1 && done_cnt == 0, "R10 timeout abort", err, 1);
         chk(hi == LIM, "R10 timeout length", hi, LIM);
         @(negedge clk);
         chk(busy == 1'b0, "R10 idle after timeout", busy, 0);
      end

      // constrained random runs
      for (int r = 0; r < 12; r++) begin
         for (int i = 0; i < N; i++)
            gain[i] = (($urandom % 4) == 0) ? (1 + $urandom % 16'h2000) : (16'h2000 + $urandom % 16'h5FFF);
         run(N'($urandom), $urandom % 24, "R6 random");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd1357));
   end
endmodule